// File: doc/BRIEF.md
# Descriptor-Chain Transmit DMA Engine

This block is a single-channel transmit DMA engine. Software builds a chain of four-word buffer descriptors in memory, hands each one to the hardware by setting its owner bit, and starts the engine by writing the address of the first descriptor into the head-pointer register. The engine reads each descriptor, streams the bytes of its buffer out on a valid/ready byte interface, then writes the descriptor's mode word back with the owner bit cleared. It then follows the next pointer.

When the chain ends (the next pointer is zero), the engine marks end-of-queue in the mode word it writes back. It then clears the head pointer and goes idle, so software can restart it by writing a new head. A descriptor found without the owner bit stops the engine without sending anything. The completion-pointer register holds the address of the last descriptor the engine finished. Software writes that register to acknowledge.

Descriptor layout, by byte offset from the descriptor address: +0 next pointer, +4 buffer pointer, +8 buffer length (the low 11 bits give the byte count), +12 mode word. Mode bit 31 marks start of packet, bit 30 end of packet, bit 29 hardware ownership and bit 28 end of queue. Frames under 60 bytes are padded by software before they are submitted.

Top module: `txd_chain_dma`

## Requirements
- R1: After reset, the control, head and completion registers read 0, `tx_valid` is low and `mem_req` is low.
- R2: The engine starts only when it is idle. A non-zero head write with the channel enabled makes it read the four descriptor words at head+0, +4, +8 and +12, in that order. A memory request holds its address until `mem_ack`.
- R3: The engine streams the number of bytes given by the low 11 bits of the buffer-length word, starting at the buffer pointer, which may be at any byte alignment. The byte at address a is bits 8*(a mod 4)+7 down to 8*(a mod 4) of the 32-bit word at address a with its two low bits cleared.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R5: `tx_last` is high only on the final byte of a descriptor whose mode bit 30 is set.
- R6: After the bytes of a descriptor are sent, the engine writes the mode word back to descriptor+12. In that write bit 29 is cleared and all other bits are kept, except bit 28, which is set exactly when the next pointer is zero.
- R7: A non-zero next pointer makes the engine go on to that descriptor. A zero next pointer leaves the head register reading 0 and the engine idle.
- R8: A fetched descriptor with mode bit 29 clear produces no stream bytes and no memory write. It leaves the completion register unchanged and the head register reading 0.
- R9: After a write-back, the completion register (select 3) reads that descriptor's address. A software write to it sets the value read back.
- R10: A head write while the head register is non-zero is ignored.
- R11: Control register (select 0) bit 0 enables the channel. While it is 0 no descriptor fetch starts, and setting it starts the pending chain.
- R12: Writing 1 to bit 0 of the soft-reset register (select 1) makes it read 1 for one cycle and then 0. It clears the head and completion registers and drops the stream and memory request. The control register is left unchanged.
- R13: A descriptor with a buffer length of zero sends no bytes but is still written back and completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 soft reset, 2 head, 3 completion |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` (combinational) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Access completes in this cycle |
| mem_rdata | input | 32 | Read data, valid while `mem_ack` is high |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of an end-of-packet descriptor |

## Verification
The engine is tried with four kinds of chain:
- A single aligned descriptor. This tells whether the fetch order, the end-of-queue write-back and the completion value are right in the simplest case.
- A three-descriptor chain with an odd-aligned buffer, a zero-length middle descriptor and an end-of-packet flag only on the last one. This separates byte-lane selection, last-flag gating and chain following from one another.
- A descriptor without the owner bit, and a chain started while the channel is disabled. These show that nothing is read, sent or written back when it must not be.
- A soft reset issued while a byte is stalled under back-pressure. This shows which state is cleared and which is kept.

The sink's ready pattern is pseudo-random, so every byte is checked both against the expected value and for stability while stalled.

// File: rtl/txd_pkg.sv
package txd_pkg;

    localparam int WORD_W  = 32;
    localparam int LEN_W   = 11;
    localparam int SEL_W   = 2;

    localparam int MB_SOP  = 31;
    localparam int MB_EOP  = 30;
    localparam int MB_OWN  = 29;
    localparam int MB_EOQ  = 28;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_SRST = 2'd1,
        SEL_HEAD = 2'd2,
        SEL_CMPL = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_RDWORD,
        ST_EMIT,
        ST_WBACK
    } eng_st_e;

    typedef struct packed {
        logic [WORD_W-1:0] nxt;
        logic [WORD_W-1:0] bptr;
        logic [LEN_W-1:0]  len;
        logic [WORD_W-1:0] mode;
    } desc_t;

    function automatic logic [7:0] pick_byte(input logic [WORD_W-1:0] w,
                                             input logic [1:0] lane);
        return w[8*lane +: 8];
    endfunction

    function automatic logic [WORD_W-1:0] retire_mode(input logic [WORD_W-1:0] m,
                                                      input logic chain_end);
        logic [WORD_W-1:0] r;
        r = m;
        r[MB_OWN] = 1'b0;
        r[MB_EOQ] = chain_end;
        return r;
    endfunction

endpackage

// File: rtl/txd_regs.sv
module txd_regs
    import txd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic [WORD_W-1:0] head_q,
    input  logic [WORD_W-1:0] cmpl_q,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              chan_en,
    output logic              soft_clr,
    output logic              head_wr,
    output logic              cmpl_wr
);

    logic ctrl_q;
    logic srst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= 1'b0;
            srst_q <= 1'b0;
        end else begin
            srst_q <= 1'b0;
            if (reg_we && reg_sel == SEL_CTRL)
                ctrl_q <= reg_wdata[0];
            if (reg_we && reg_sel == SEL_SRST && reg_wdata[0])
                srst_q <= 1'b1;
        end
    end

    assign chan_en  = ctrl_q;
    assign soft_clr = srst_q;
    assign head_wr  = reg_we && reg_sel == SEL_HEAD;
    assign cmpl_wr  = reg_we && reg_sel == SEL_CMPL;

    always_comb begin
        unique case (reg_sel)
            SEL_CTRL: reg_rdata = {{(WORD_W-1){1'b0}}, ctrl_q};
            SEL_SRST: reg_rdata = {{(WORD_W-1){1'b0}}, srst_q};
            SEL_HEAD: reg_rdata = head_q;
            default:  reg_rdata = cmpl_q;
        endcase
    end

    // R12
    srst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        srst_q |=> !srst_q);

endmodule

// File: rtl/txd_engine.sv
module txd_engine
    import txd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_clr,
    input  logic              chan_en,
    input  logic              head_wr,
    input  logic              cmpl_wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] head_q,
    output logic [WORD_W-1:0] cmpl_q,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_last
);

    localparam logic [WORD_W-1:0] MODE_OFS = WORD_W'(12);

    eng_st_e           st;
    desc_t             desc_q;
    logic [1:0]        widx;
    logic [WORD_W-1:0] bptr;
    logic [LEN_W-1:0]  rem;
    logic [WORD_W-1:0] word_q;
    logic              chain_end;

    assign chain_end = (desc_q.nxt == '0);

    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = '0;
        unique case (st)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = head_q + WORD_W'({widx, 2'b00});
            end
            ST_RDWORD: begin
                mem_req  = 1'b1;
                mem_addr = {bptr[WORD_W-1:2], 2'b00};
            end
            ST_WBACK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = head_q + MODE_OFS;
            end
            default: ;
        endcase
    end

    assign mem_wdata = retire_mode(desc_q.mode, chain_end);
    assign tx_valid  = (st == ST_EMIT);
    assign tx_data   = pick_byte(word_q, bptr[1:0]);
    assign tx_last   = tx_valid && rem == LEN_W'(1) && desc_q.mode[MB_EOP];

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            st     <= ST_IDLE;
            head_q <= '0;
            cmpl_q <= '0;
            desc_q <= '0;
            widx   <= '0;
            bptr   <= '0;
            rem    <= '0;
            word_q <= '0;
        end else begin
            if (cmpl_wr)
                cmpl_q <= wdata;
            unique case (st)
                ST_IDLE: begin
                    if (head_wr && head_q == '0)
                        head_q <= wdata;
                    else if (chan_en && head_q != '0) begin
                        widx <= '0;
                        st   <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        unique case (widx)
                            2'd0: desc_q.nxt  <= mem_rdata;
                            2'd1: desc_q.bptr <= mem_rdata;
                            2'd2: desc_q.len  <= mem_rdata[LEN_W-1:0];
                            default: desc_q.mode <= mem_rdata;
                        endcase
                        widx <= widx + 2'd1;
                        if (widx == 2'd3)
                            st <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (!desc_q.mode[MB_OWN]) begin
                        head_q <= '0;
                        st     <= ST_IDLE;
                    end else if (desc_q.len == '0) begin
                        st <= ST_WBACK;
                    end else begin
                        bptr <= desc_q.bptr;
                        rem  <= desc_q.len;
                        st   <= ST_RDWORD;
                    end
                end
                ST_RDWORD: begin
                    if (mem_ack) begin
                        word_q <= mem_rdata;
                        st     <= ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    if (tx_ready) begin
                        bptr <= bptr + WORD_W'(1);
                        rem  <= rem - LEN_W'(1);
                        if (rem == LEN_W'(1))
                            st <= ST_WBACK;
                        else if (bptr[1:0] == 2'd3)
                            st <= ST_RDWORD;
                    end
                end
                ST_WBACK: begin
                    if (mem_ack) begin
                        cmpl_q <= head_q;
                        head_q <= desc_q.nxt;
                        st     <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R4
    stream_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !soft_clr) |=>
            (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R5
    last_valid_chk: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid);

    // R2
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !soft_clr) |=> (mem_req && $stable(mem_addr)));

    // R6
    wback_owner_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_req && mem_addr[1:0] == 2'b00 && !mem_wdata[MB_OWN]));

    // R12
    soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
        soft_clr |=> (head_q == '0 && cmpl_q == '0 && !tx_valid && !mem_req));

endmodule

// File: rtl/txd_chain_dma.sv
module txd_chain_dma
    import txd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_last
);

    logic [WORD_W-1:0] head_q;
    logic [WORD_W-1:0] cmpl_q;
    logic              chan_en;
    logic              soft_clr;
    logic              head_wr;
    logic              cmpl_wr;

    txd_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .head_q    (head_q),
        .cmpl_q    (cmpl_q),
        .reg_rdata (reg_rdata),
        .chan_en   (chan_en),
        .soft_clr  (soft_clr),
        .head_wr   (head_wr),
        .cmpl_wr   (cmpl_wr)
    );

    txd_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .soft_clr  (soft_clr),
        .chan_en   (chan_en),
        .head_wr   (head_wr),
        .cmpl_wr   (cmpl_wr),
        .wdata     (reg_wdata),
        .head_q    (head_q),
        .cmpl_q    (cmpl_q),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_data   (tx_data),
        .tx_last   (tx_last)
    );

endmodule

// File: tb/tb_txd_chain_dma.sv
`timescale 1ns/1ps
module tb_txd_chain_dma;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        tx_valid, tx_last;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_data;

    always #2.5 clk = ~clk;

    txd_chain_dma dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_last(tx_last)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] mem [0:511];
    int rd_count = 0;
    int wr_count = 0;
    logic [31:0] rd_log [$];
    logic [8:0]  exp_q [$];
    int   ready_mode = 2;
    logic [15:0] lfsr = 16'hACE1;
    bit   hold_skip = 0;
    bit   hold_pend = 0;
    logic [7:0] hold_d;
    logic hold_l;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory model: one idle cycle, then an acknowledge cycle
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[10:2]];
            if (!mem_we) begin
                rd_count++;
                rd_log.push_back(mem_addr);
            end
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && mem_ack && mem_we) begin
                mem[mem_addr[10:2]] <= mem_wdata;
                wr_count++;
            end
        end
    end

    // monitor: ready for the coming edge is set first, then the handshake is judged
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tx_ready = (ready_mode == 0) ? 1'b0 : (ready_mode == 1) ? 1'b1 : (lfsr[0] | lfsr[3]);
        if (!rst) begin
            if (hold_pend && !hold_skip)
                chk(tx_valid && tx_data == hold_d && tx_last == hold_l, "R4 hold",
                    {22'd0, tx_valid, tx_last, tx_data}, {22'd0, 1'b1, hold_l, hold_d});
            hold_pend = tx_valid && !tx_ready;
            hold_d = tx_data;
            hold_l = tx_last;
            if (tx_valid && tx_ready) begin
                if (exp_q.size() == 0)
                    chk(0, "R3/R8 unexpected byte", {24'd0, tx_data}, 32'hFFFFFFFF);
                else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    chk(tx_data == e[7:0] && tx_last == e[8], "R3/R5 byte",
                        {23'd0, tx_last, tx_data}, {23'd0, e});
                end
            end
        end
    end

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [31:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic push_bytes(input logic [31:0] b, input int len, input bit eop);
        for (int i = 0; i < len; i++) begin
            logic [31:0] a;
            logic [31:0] w;
            a = b + i;
            w = mem[a[10:2]];
            exp_q.push_back({eop && (i == len - 1), w[8*a[1:0] +: 8]});
        end
    endtask

    task automatic put_desc(input logic [31:0] at, input logic [31:0] nxt,
                            input logic [31:0] bp, input logic [31:0] len,
                            input logic [31:0] mode);
        mem[at[10:2]]     = nxt;
        mem[at[10:2] + 1] = bp;
        mem[at[10:2] + 2] = len;
        mem[at[10:2] + 3] = mode;
    endtask

    task automatic wait_idle();
        logic [31:0] h;
        for (int i = 0; i < 2000; i++) begin
            reg_read(2'd2, h);
            if (h == 0) break;
        end
        repeat (4) @(negedge clk);
    endtask

    localparam logic [31:0] SOP = 32'h8000_0000;
    localparam logic [31:0] EOP = 32'h4000_0000;
    localparam logic [31:0] OWN = 32'h2000_0000;
    localparam logic [31:0] EOQ = 32'h1000_0000;

    initial begin
        logic [31:0] r;
        int rc, wc;
        for (int i = 0; i < 512; i++)
            mem[i] = {8'(i * 4 + 3) ^ 8'h5A, 8'(i * 4 + 2) ^ 8'h5A,
                      8'(i * 4 + 1) ^ 8'h5A, 8'(i * 4) ^ 8'h5A};
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        reg_read(2'd0, r); chk(r == 0, "R1 ctrl", r, 0);
        reg_read(2'd2, r); chk(r == 0, "R1 head", r, 0);
        reg_read(2'd3, r); chk(r == 0, "R1 cmpl", r, 0);
        chk(!tx_valid && !mem_req, "R1 outputs", {tx_valid, mem_req}, 0);

        // single aligned descriptor: R2 R3 R6 R9
        put_desc(32'h100, 0, 32'h400, 5, SOP | EOP | OWN | 5);
        push_bytes(32'h400, 5, 1);
        reg_write(2'd0, 1);
        rd_log.delete();
        reg_write(2'd2, 32'h100);
        wait_idle();
        chk(rd_log.size() >= 4, "R2 fetch count", rd_log.size(), 4);
        for (int i = 0; i < 4 && i < rd_log.size(); i++)
            chk(rd_log[i] == 32'h100 + 4 * i, "R2 fetch order", rd_log[i], 32'h100 + 4 * i);
        chk(exp_q.size() == 0, "R3 all bytes sent", exp_q.size(), 0);
        chk(mem[32'h10C >> 2] == (SOP | EOP | EOQ | 5), "R6 writeback eoq",
            mem[32'h10C >> 2], SOP | EOP | EOQ | 5);
        reg_read(2'd3, r); chk(r == 32'h100, "R9 cmpl", r, 32'h100);
        reg_read(2'd2, r); chk(r == 0, "R7 head cleared", r, 0);

        // chain: odd alignment, zero length, last only on final: R3 R5 R7 R10 R13
        put_desc(32'h200, 32'h220, 32'h501, 9, SOP | OWN | 9);
        put_desc(32'h220, 32'h240, 32'h580, 0, OWN);
        put_desc(32'h240, 0, 32'h602, 6, EOP | OWN | 6);
        push_bytes(32'h501, 9, 0);
        push_bytes(32'h602, 6, 1);
        reg_write(2'd2, 32'h200);
        reg_write(2'd2, 32'h998);
        reg_read(2'd2, r); chk(r == 32'h200, "R10 head write ignored", r, 32'h200);
        wait_idle();
        chk(exp_q.size() == 0, "R3 chain bytes", exp_q.size(), 0);
        chk(mem[32'h20C >> 2] == (SOP | 9), "R6 first no eoq", mem[32'h20C >> 2], SOP | 9);
        chk(mem[32'h22C >> 2] == 0, "R13 zero length written back", mem[32'h22C >> 2], 0);
        chk(mem[32'h24C >> 2] == (EOP | EOQ | 6), "R7 chain end eoq",
            mem[32'h24C >> 2], EOP | EOQ | 6);
        reg_read(2'd3, r); chk(r == 32'h240, "R7 cmpl last", r, 32'h240);

        // owner clear: R8
        put_desc(32'h300, 0, 32'h400, 4, SOP | EOP | 4);
        wc = wr_count;
        reg_write(2'd2, 32'h300);
        wait_idle();
        chk(wr_count == wc, "R8 no writeback", wr_count, wc);
        chk(mem[32'h30C >> 2] == (SOP | EOP | 4), "R8 mode untouched",
            mem[32'h30C >> 2], SOP | EOP | 4);
        reg_read(2'd3, r); chk(r == 32'h240, "R8 cmpl unchanged", r, 32'h240);

        // software acknowledge write: R9
        reg_write(2'd3, 32'h1234_5678);
        reg_read(2'd3, r); chk(r == 32'h1234_5678, "R9 cmpl write", r, 32'h1234_5678);

        // disabled channel: R11
        reg_write(2'd0, 0);
        put_desc(32'h340, 0, 32'h410, 3, SOP | EOP | OWN | 3);
        rc = rd_count;
        reg_write(2'd2, 32'h340);
        repeat (20) @(negedge clk);
        chk(rd_count == rc, "R11 no fetch while disabled", rd_count, rc);
        reg_read(2'd2, r); chk(r == 32'h340, "R11 head pending", r, 32'h340);
        push_bytes(32'h410, 3, 1);
        reg_write(2'd0, 1);
        wait_idle();
        chk(exp_q.size() == 0, "R11 runs after enable", exp_q.size(), 0);
        reg_read(2'd3, r); chk(r == 32'h340, "R11 cmpl", r, 32'h340);

        // soft reset under back-pressure: R12
        ready_mode = 0;
        hold_skip = 1;
        put_desc(32'h380, 0, 32'h700, 40, SOP | EOP | OWN | 40);
        reg_write(2'd2, 32'h380);
        for (int i = 0; i < 200 && !tx_valid; i++) @(negedge clk);
        chk(tx_valid, "R12 stalled byte present", tx_valid, 1);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = 2'd1; reg_wdata = 1;
        @(negedge clk);
        reg_we = 1'b0;
        #1 chk(reg_rdata == 1, "R12 srst reads 1", reg_rdata, 1);
        @(negedge clk);
        #1 chk(reg_rdata == 0, "R12 srst self clears", reg_rdata, 0);
        chk(!tx_valid && !mem_req, "R12 stream dropped", {tx_valid, mem_req}, 0);
        reg_read(2'd2, r); chk(r == 0, "R12 head cleared", r, 0);
        reg_read(2'd3, r); chk(r == 0, "R12 cmpl cleared", r, 0);
        reg_read(2'd0, r); chk(r == 1, "R12 ctrl kept", r, 1);
        ready_mode = 2;
        repeat (2) @(negedge clk);
        hold_skip = 0;

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule